// File: doc/BRIEF.md
# Timer Channel Output Pin Controller

This block owns the output pins of a multi-channel timer array. Each channel has one output level bit, and that bit drives the channel's pin directly. The counters that raise interrupts are outside the block. It receives their single-cycle interrupt pulses, one per channel, and turns them into pin transitions. A channel works in one of two ways. In toggle mode, its own pulse inverts the pin. In set/reset mode, its own pulse and the pulse of the next channel up drive the level, which makes it possible to build PWM from a master/slave counter pair.

Four per-channel registers sit on a simple write port and a combinational read port: mode, polarity, enable and level.

- The polarity bit swaps which of the two pulses sets the pin and which clears it.
- The enable bit decides who owns the level bit. When it is 1, the interrupt pulses own the bit. When it is 0, software writes own it.
- Reading the level register always returns the current pin state.

Top module: `tmr_outpin_ctrl`

## Requirements
- R1: A synchronous reset, active high, clears every mode, polarity, enable and level bit to 0 on the next rising edge.
- R2: The write port decodes `wr_sel` as follows: 0 is mode, 1 is polarity, 2 is enable and 3 is level. A write takes effect on the rising edge where `wr_en` is 1. `rd_data` shows the register picked by `rd_sel` (same encoding) combinationally, and reading the level register returns `pin_out`.
- R3: Toggle mode applies when a channel's mode bit is 0 and its enable bit is 1. A pulse on that channel's own `tick` bit inverts its pin on the same edge. The polarity bit and the pulse of the next channel have no effect.
- R4: Forward set/reset applies when mode is 1, polarity is 0 and enable is 1. The channel's own pulse sets its pin to 1, and the pulse of the next channel clears it to 0.
- R5: Reverse set/reset applies when mode is 1, polarity is 1 and enable is 1. The channel's own pulse clears its pin, and the pulse of the next channel sets it.
- R6: In set/reset mode, when the set pulse and the clear pulse arrive on the same edge, the pin goes to 0.
- R7: A level write leaves the pin of every enabled channel unchanged. In the same write, the channels whose enable bit is 0 are still loaded.
- R8: While a channel's enable bit is 0, its pin ignores all pulses. A level write loads the written bit into that pin, and the pin holds otherwise.
- R9: The next channel above the highest channel is channel 0. Its pulse acts as the partner pulse of the highest channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register picked for a write |
| wr_data | input | NUM_CH | Write data, one bit per channel |
| rd_sel | input | 2 | Register picked for a read |
| rd_data | output | NUM_CH | Read data of the picked register |
| tick | input | NUM_CH | Timer interrupt pulses, one per channel |
| pin_out | output | NUM_CH | Channel output pins |

## Verification
The bench tries the event path with several pulse patterns:

- A lone own pulse and a lone partner pulse under each polarity. These show which input sets the pin, which clears it, and which one toggle mode listens to.
- A pulse pattern where both partners fire together on one channel while a neighbour sees only its set pulse. This separates the clear-wins rule from plain set or clear behaviour.
- A pulse on channel 0 with the top channel in set/reset mode. This shows the wrap-around of the partner index.

Level writes are made under a mixed enable mask. These show that software reaches exactly the channels it owns, and that pulses reach only the enabled ones.

// File: rtl/tmr_out_pkg.sv
package tmr_out_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_POL  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_LVL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OUT_TOGGLE = 1'b0,
        OUT_SETCLR = 1'b1
    } out_mode_e;

    // per-channel event request produced from the interrupt pulses
    typedef struct packed {
        logic set;
        logic clr;
        logic flip;
    } pin_evt_t;

    localparam pin_evt_t EVT_NONE = '{set: 1'b0, clr: 1'b0, flip: 1'b0};

    // index of the partner channel whose pulse pairs with channel ch
    function automatic int partner_idx(input int ch, input int n);
        return (ch + 1) % n;
    endfunction

    function automatic pin_evt_t decode_evt(
        input logic mode,
        input logic pol,
        input logic en,
        input logic own_tick,
        input logic partner_tick
    );
        pin_evt_t e;
        e = EVT_NONE;
        if (en) begin
            if (out_mode_e'(mode) == OUT_TOGGLE) begin
                e.flip = own_tick;
            end else if (pol) begin
                e.set = partner_tick;
                e.clr = own_tick;
            end else begin
                e.set = own_tick;
                e.clr = partner_tick;
            end
        end
        return e;
    endfunction

    // clear has priority over set; flip only comes from toggle mode
    function automatic logic next_level(input logic cur, input pin_evt_t e);
        logic nxt;
        if (e.clr) begin
            nxt = 1'b0;
        end else if (e.set) begin
            nxt = 1'b1;
        end else if (e.flip) begin
            nxt = ~cur;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tmr_out_cfg_regs.sv
module tmr_out_cfg_regs
    import tmr_out_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [NUM_CH-1:0] wr_data,
    output logic [NUM_CH-1:0] mode_q,
    output logic [NUM_CH-1:0] pol_q,
    output logic [NUM_CH-1:0] en_q
);

    logic wr_mode;
    logic wr_pol;
    logic wr_en_reg;

    always_comb begin
        wr_mode   = wr_en && (wr_sel == SEL_MODE);
        wr_pol    = wr_en && (wr_sel == SEL_POL);
        wr_en_reg = wr_en && (wr_sel == SEL_EN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else begin
            if (wr_mode) begin
                mode_q <= wr_data;
            end
            if (wr_pol) begin
                pol_q <= wr_data;
            end
            if (wr_en_reg) begin
                en_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/tmr_out_evt_decode.sv
module tmr_out_evt_decode
    import tmr_out_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                       [NUM_CH-1:0] mode_q,
    input  logic                       [NUM_CH-1:0] pol_q,
    input  logic                       [NUM_CH-1:0] en_q,
    input  logic                       [NUM_CH-1:0] tick,
    output pin_evt_t                   [NUM_CH-1:0] evt
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int PARTNER = partner_idx(ch, NUM_CH);

        always_comb begin
            evt[ch] = decode_evt(mode_q[ch], pol_q[ch], en_q[ch],
                                 tick[ch], tick[PARTNER]);
        end
    end

endmodule

// File: rtl/tmr_out_level_reg.sv
module tmr_out_level_reg
    import tmr_out_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pin_evt_t    [NUM_CH-1:0] evt,
    input  logic        [NUM_CH-1:0] en_q,
    input  logic                     sw_load,
    input  logic        [NUM_CH-1:0] sw_data,
    output logic        [NUM_CH-1:0] level_q
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
        logic nxt;

        // enabled: only events; disabled: only software loads
        always_comb begin
            if (en_q[ch]) begin
                nxt = next_level(level_q[ch], evt[ch]);
            end else if (sw_load) begin
                nxt = sw_data[ch];
            end else begin
                nxt = level_q[ch];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                level_q[ch] <= 1'b0;
            end else begin
                level_q[ch] <= nxt;
            end
        end
    end

endmodule

// File: rtl/tmr_outpin_ctrl.sv
module tmr_outpin_ctrl
    import tmr_out_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [NUM_CH-1:0] rd_data,
    input  logic [NUM_CH-1:0] tick,
    output logic [NUM_CH-1:0] pin_out
);

    logic     [NUM_CH-1:0] cfg_mode;
    logic     [NUM_CH-1:0] cfg_pol;
    logic     [NUM_CH-1:0] cfg_en;
    logic     [NUM_CH-1:0] level_q;
    pin_evt_t [NUM_CH-1:0] evt;
    reg_sel_e              wsel;
    reg_sel_e              rsel;
    logic                  sw_load;

    always_comb begin
        wsel    = reg_sel_e'(wr_sel);
        rsel    = reg_sel_e'(rd_sel);
        sw_load = wr_en && (wsel == SEL_LVL);
    end

    tmr_out_cfg_regs #(.NUM_CH(NUM_CH)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wsel),
        .wr_data (wr_data),
        .mode_q  (cfg_mode),
        .pol_q   (cfg_pol),
        .en_q    (cfg_en)
    );

    tmr_out_evt_decode #(.NUM_CH(NUM_CH)) i_dec (
        .mode_q (cfg_mode),
        .pol_q  (cfg_pol),
        .en_q   (cfg_en),
        .tick   (tick),
        .evt    (evt)
    );

    tmr_out_level_reg #(.NUM_CH(NUM_CH)) i_lvl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .en_q    (cfg_en),
        .sw_load (sw_load),
        .sw_data (wr_data),
        .level_q (level_q)
    );

    assign pin_out = level_q;

    always_comb begin
        unique case (rsel)
            SEL_MODE: rd_data = cfg_mode;
            SEL_POL:  rd_data = cfg_pol;
            SEL_EN:   rd_data = cfg_en;
            SEL_LVL:  rd_data = level_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_outpin_ctrl_chk.sv
module tmr_outpin_ctrl_chk
    import tmr_out_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [NUM_CH-1:0] wr_data,
    input logic [NUM_CH-1:0] tick,
    input logic [NUM_CH-1:0] pin_out,
    input logic [NUM_CH-1:0] cfg_mode,
    input logic [NUM_CH-1:0] cfg_pol,
    input logic [NUM_CH-1:0] cfg_en
);

    logic lvl_wr;
    assign lvl_wr = wr_en && (wr_sel == SEL_LVL);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && cfg_mode == '0 && cfg_pol == '0 && cfg_en == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int P = partner_idx(c, NUM_CH);

        assert_toggle_flips_R3: assert property (@(posedge clk) disable iff (rst)
            (cfg_en[c] && !cfg_mode[c] && tick[c]) |=> (pin_out[c] != $past(pin_out[c])));

        assert_forward_set_R4: assert property (@(posedge clk) disable iff (rst)
            (cfg_en[c] && cfg_mode[c] && !cfg_pol[c] && tick[c] && !tick[P]) |=> pin_out[c]);

        assert_reverse_set_R5: assert property (@(posedge clk) disable iff (rst)
            (cfg_en[c] && cfg_mode[c] && cfg_pol[c] && tick[P] && !tick[c]) |=> pin_out[c]);

        assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
            (cfg_en[c] && cfg_mode[c] && tick[c] && tick[P]) |=> !pin_out[c]);

        assert_sw_blocked_R7: assert property (@(posedge clk) disable iff (rst)
            (cfg_en[c] && !tick[c] && !tick[P]) |=> $stable(pin_out[c]));

        assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (!cfg_en[c] && !lvl_wr) |=> $stable(pin_out[c]));

        assert_disabled_load_R8: assert property (@(posedge clk) disable iff (rst)
            (!cfg_en[c] && lvl_wr) |=> (pin_out[c] == $past(wr_data[c])));
    end

endmodule

bind tmr_outpin_ctrl tmr_outpin_ctrl_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tick     (tick),
    .pin_out  (pin_out),
    .cfg_mode (cfg_mode),
    .cfg_pol  (cfg_pol),
    .cfg_en   (cfg_en)
);

// File: tb/test_tmr_outpin_ctrl.sv
module test_tmr_outpin_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam logic [1:0] S_MODE = 2'd0;
    localparam logic [1:0] S_POL  = 2'd1;
    localparam logic [1:0] S_EN   = 2'd2;
    localparam logic [1:0] S_LVL  = 2'd3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [NUM_CH-1:0] wr_data = '0;
    logic [1:0]        rd_sel = '0;
    logic [NUM_CH-1:0] rd_data;
    logic [NUM_CH-1:0] tick = '0;
    logic [NUM_CH-1:0] pin_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_outpin_ctrl #(.NUM_CH(NUM_CH)) i_tmr_outpin_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .tick    (tick),
        .pin_out (pin_out)
    );

    task automatic check(input string req, input logic [NUM_CH-1:0] got,
                         input logic [NUM_CH-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [NUM_CH-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [NUM_CH-1:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] t);
        @(negedge clk);
        tick = t;
        @(negedge clk);
        tick = '0;
    endtask

    task automatic setup(input logic [NUM_CH-1:0] lvl, input logic [NUM_CH-1:0] mode,
                         input logic [NUM_CH-1:0] pol, input logic [NUM_CH-1:0] en);
        wr(S_EN, '0);
        wr(S_LVL, lvl);
        wr(S_MODE, mode);
        wr(S_POL, pol);
        wr(S_EN, en);
    endtask

    task automatic t_reset;
        logic [NUM_CH-1:0] v;
        check("R1 pin", pin_out, '0);
        rd(S_MODE, v); check("R1 mode", v, '0);
        rd(S_POL, v);  check("R1 pol", v, '0);
        rd(S_EN, v);   check("R1 en", v, '0);
    endtask

    task automatic t_regs;
        logic [NUM_CH-1:0] v;
        wr(S_MODE, 8'hA5);
        wr(S_POL, 8'h3C);
        wr(S_EN, 8'h00);
        wr(S_LVL, 8'h96);
        rd(S_MODE, v); check("R2 mode readback", v, 8'hA5);
        rd(S_POL, v);  check("R2 pol readback", v, 8'h3C);
        rd(S_EN, v);   check("R2 en readback", v, 8'h00);
        rd(S_LVL, v);  check("R2 level readback", v, 8'h96);
        check("R8 sw load pin", pin_out, 8'h96);
    endtask

    task automatic t_toggle;
        setup(8'h00, 8'h00, 8'hFF, 8'hFF);
        pulse(8'h01);
        check("R3 toggle up", pin_out, 8'h01);
        pulse(8'h01);
        check("R3 toggle down", pin_out, 8'h00);
        pulse(8'h02);
        check("R3 partner no effect", pin_out, 8'h02);
    endtask

    task automatic t_forward;
        setup(8'h00, 8'hFF, 8'h00, 8'hFF);
        pulse(8'h01);
        check("R4 own sets", pin_out, 8'h01);
        pulse(8'h02);
        check("R4 partner clears", pin_out, 8'h02);
    endtask

    task automatic t_reverse;
        setup(8'h00, 8'hFF, 8'hFF, 8'hFF);
        pulse(8'h04);
        check("R5 partner sets", pin_out, 8'h02);
        pulse(8'h02);
        check("R5 own clears", pin_out, 8'h01);
    endtask

    task automatic t_clear_wins;
        setup(8'hFF, 8'hFF, 8'h00, 8'hFF);
        pulse(8'h03);
        check("R6 forward both", pin_out, 8'h7E);
        setup(8'h00, 8'hFF, 8'hFF, 8'hFF);
        pulse(8'h03);
        check("R6 reverse both", pin_out, 8'h80);
    endtask

    task automatic t_ownership;
        logic [NUM_CH-1:0] v;
        setup(8'h00, 8'h00, 8'h00, 8'h0F);
        wr(S_LVL, 8'hFF);
        check("R7 partial sw write", pin_out, 8'hF0);
        pulse(8'hFF);
        check("R8 disabled ignore ticks", pin_out, 8'hFF);
        wr(S_LVL, 8'h00);
        rd(S_LVL, v);
        check("R7 enabled kept", v, 8'h0F);
    endtask

    task automatic t_wrap;
        setup(8'h80, 8'hFF, 8'h00, 8'hFF);
        pulse(8'h01);
        check("R9 top channel cleared by ch0", pin_out, 8'h01);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_toggle();
        t_forward();
        t_reverse();
        t_clear_wins();
        t_ownership();
        t_wrap();
        wr(S_MODE, 8'h5A);
        t_reset_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule